// File: doc/BRIEF.md
# Connection Memory Block-Fill Controller

This block holds the 16-bit fill-mode register of a TDM switch and runs the bulk initialisation of its connection memories. Firmware writes the register once, giving a 3-bit backplane fill value, a 4-bit local fill value and a start bit in a single write. If the master block-programming enable input is high when the start bit goes from 0 to 1, the sequencer writes every address of three memories: the backplane connection memory, and the low and high halves of the local connection memory. It writes one word per clock to each memory, in address order. Each fill value goes into its memory word at a fixed bit offset, and every other bit of the word is written as zero.

The fill is timed in frames. A one-clock frame pulse marks each frame boundary. The second frame pulse after the start edge ends the fill, and the hardware then clears the start bit, so software can poll the register to see that the fill has finished. Software can cancel a fill in two ways: by writing the start bit to 0, or by dropping the master enable. Either one stops the memory writes at once and leaves the memories partly written.

Top module: `cm_fill_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads 0, `fill_busy` is 0, and no memory write enable is asserted.
- R2: A register write appears in `cfg_rdata` on the clock after the strobe. Bits 15..10 always read 0. Bits 1..0 read back as written and have no effect on filling.
- R3: A fill launches only on a write that changes the start bit (bit 2) from 0 to 1 while `blk_prog_en` is 1. Writing the start bit while the enable is 0 does not launch a fill. Raising the enable afterwards, while the start bit is already 1, does not launch one either.
- R4: Every backplane fill word carries register bits 9..7 in word bits 13..11, with all other bits 0.
- R5: Every local-low fill word carries register bits 6..3 in word bits 15..12, with all other bits 0. Every local-high fill word is all zero.
- R6: A fill writes each memory exactly once at each address from 0 to DEPTH-1, in ascending order, one address per clock. The first write enable is seen on the second clock after the launching strobe.
- R7: The fill ends on the second frame pulse seen while busy. On the next clock `fill_busy` is 0 and the start bit reads 0. One frame pulse alone leaves the fill running.
- R8: While a fill is busy, writing the start bit as 0 or setting `blk_prog_en` to 0 stops the memory writes from the next clock. It also clears `fill_busy`, and the start bit reads 0.
- R9: Both fill values are captured by the launching write. A later write that keeps the start bit at 1 changes the register contents but not the data being filled.
- R10: If a register write falls in the same cycle as the completing frame pulse, the written value is what the register holds afterwards, and no new fill starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 16 | Mode register write data |
| cfg_rdata | output | 16 | Mode register read value |
| blk_prog_en | input | 1 | Master block-programming enable from the control register |
| frame_pulse | input | 1 | One-clock frame boundary pulse |
| fill_busy | output | 1 | Fill in progress |
| bp_we | output | 1 | Backplane memory write enable |
| bp_addr | output | AW | Backplane memory address |
| bp_wdata | output | 16 | Backplane memory write data |
| lo_we | output | 1 | Local-low memory write enable |
| lo_addr | output | AW | Local-low memory address |
| lo_wdata | output | 16 | Local-low memory write data |
| hi_we | output | 1 | Local-high memory write enable |
| hi_addr | output | AW | Local-high memory address |
| hi_wdata | output | 16 | Local-high memory write data |

## Verification
The hardware clear of the start bit, caused by the completing frame pulse, can land in the same cycle as a firmware register write. The bench provokes this by raising the second frame pulse and a write (start bit 1, low bits 1 and 1) on the same clock. It then checks that the register reads exactly the written value, that `fill_busy` drops, and that no memory write follows. Two other pairs are also checked: an abort coinciding with writes already in flight, and a start-bit rewrite during a fill. In both cases the scoreboard counts the memory writes exactly.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
  localparam int REG_W     = 16;
  localparam int HELD_W    = 10;
  localparam int BPV_W     = 3;
  localparam int LCV_W     = 4;
  localparam int START_BIT = 2;
  localparam int BP_POS    = 11;
  localparam int LO_POS    = 12;
  localparam int N_TGT     = 3;
  localparam int TGT_BP    = 0;
  localparam int TGT_LO    = 1;
  localparam int TGT_HI    = 2;

  // held register bits, packed so that bit 0 of the struct is register bit 0
  typedef struct packed {
    logic [BPV_W-1:0] bpv;
    logic [LCV_W-1:0] lcv;
    logic             start;
    logic [1:0]       aux;
  } mode_t;

  typedef struct packed {
    logic [BPV_W-1:0] bpv;
    logic [LCV_W-1:0] lcv;
  } fill_vals_t;

  function automatic logic [REG_W-1:0] fill_word(input int tgt, input fill_vals_t v);
    logic [REG_W-1:0] w;
    w = '0;
    case (tgt)
      TGT_BP:  w[BP_POS +: BPV_W] = v.bpv;
      TGT_LO:  w[LO_POS +: LCV_W] = v.lcv;
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/cmf_modereg.sv
module cmf_modereg
  import cmf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             hw_clr,
  output mode_t            mode_q
);
  mode_t mode_d;
  logic  mode_en;

  // a firmware write overrides the hardware clear in the same cycle
  always_comb begin
    mode_d  = mode_q;
    mode_en = wr_en | hw_clr;
    if (hw_clr) mode_d.start = 1'b0;
    if (wr_en)  mode_d = mode_t'(wr_data[HELD_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end
endmodule

// File: rtl/cmf_seq.sv
module cmf_seq
  import cmf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          abort,
  input  logic          frame_pulse,
  input  fill_vals_t    vals_in,
  output logic          busy,
  output logic          finish,
  output logic          req,
  output logic [AW-1:0] req_addr,
  output fill_vals_t    vals_q
);
  localparam int CNT_W = AW + 1;

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fcnt_q, fcnt_d;
  fill_vals_t       vals_d;
  logic             seq_en;

  always_comb begin
    finish   = busy_q & frame_pulse & fcnt_q & ~abort;
    req      = busy_q & ~abort & (cnt_q < CNT_W'(DEPTH));
    req_addr = cnt_q[AW-1:0];
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    fcnt_d   = fcnt_q;
    vals_d   = vals_q;
    seq_en   = launch | busy_q;
    if (launch) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      fcnt_d = 1'b0;
      vals_d = vals_in;
    end else if (busy_q) begin
      if (abort || finish) begin
        busy_d = 1'b0;
      end else begin
        if (req)         cnt_d  = cnt_q + CNT_W'(1);
        if (frame_pulse) fcnt_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      fcnt_q <= 1'b0;
      vals_q <= '0;
    end else if (seq_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      fcnt_q <= fcnt_d;
      vals_q <= vals_d;
    end
  end

  assign busy = busy_q;

  assert_two_frames_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && frame_pulse && fcnt_q && !abort) |=> !busy_q);
  assert_all_written_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && frame_pulse && fcnt_q && !abort) |-> (cnt_q == CNT_W'(DEPTH)));
  assert_one_frame_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fcnt_q && !abort && !launch) |=> busy_q);
endmodule

// File: rtl/cmf_wrport.sv
module cmf_wrport #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          we_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (req) begin
      addr_q <= addr;
      data_q <= data;
    end
  end
endmodule

// File: rtl/cm_fill_ctrl.sv
module cm_fill_ctrl
  import cmf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             blk_prog_en,
  input  logic             frame_pulse,
  output logic             fill_busy,
  output logic             bp_we,
  output logic [AW-1:0]    bp_addr,
  output logic [REG_W-1:0] bp_wdata,
  output logic             lo_we,
  output logic [AW-1:0]    lo_addr,
  output logic [REG_W-1:0] lo_wdata,
  output logic             hi_we,
  output logic [AW-1:0]    hi_addr,
  output logic [REG_W-1:0] hi_wdata
);
  mode_t        mode_q;
  fill_vals_t   vals_in, vals_q;
  logic         busy, finish, req, launch, abort, hw_clr;
  logic [AW-1:0] req_addr;

  logic [N_TGT-1:0] we_v;
  logic [AW-1:0]    addr_v [N_TGT];
  logic [REG_W-1:0] data_v [N_TGT];

  always_comb begin
    launch  = cfg_we & cfg_wdata[START_BIT] & ~mode_q.start & blk_prog_en & ~busy;
    abort   = busy & (~blk_prog_en | (cfg_we & ~cfg_wdata[START_BIT]));
    hw_clr  = finish | (busy & ~blk_prog_en);
    vals_in = fill_vals_t'(cfg_wdata[HELD_W-1:START_BIT+1]);
  end

  cmf_modereg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .hw_clr(hw_clr), .mode_q(mode_q)
  );

  cmf_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .abort(abort),
    .frame_pulse(frame_pulse), .vals_in(vals_in), .busy(busy),
    .finish(finish), .req(req), .req_addr(req_addr), .vals_q(vals_q)
  );

  for (genvar t = 0; t < N_TGT; t++) begin : g_port
    logic [REG_W-1:0] word;
    assign word = fill_word(t, vals_q);
    cmf_wrport #(.AW(AW), .DW(REG_W)) u_port (
      .clk(clk), .rst_n(rst_n), .req(req), .addr(req_addr), .data(word),
      .we_q(we_v[t]), .addr_q(addr_v[t]), .data_q(data_v[t])
    );
  end

  assign cfg_rdata = {{(REG_W-HELD_W){1'b0}}, mode_q};
  assign fill_busy = busy;
  assign bp_we = we_v[TGT_BP];  assign bp_addr = addr_v[TGT_BP];  assign bp_wdata = data_v[TGT_BP];
  assign lo_we = we_v[TGT_LO];  assign lo_addr = addr_v[TGT_LO];  assign lo_wdata = data_v[TGT_LO];
  assign hi_we = we_v[TGT_HI];  assign hi_addr = addr_v[TGT_HI];  assign hi_wdata = data_v[TGT_HI];

  assert_write_lands_R2_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata[HELD_W-1:0] == $past(cfg_wdata[HELD_W-1:0])));
  assert_no_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_busy && !(cfg_we && cfg_wdata[START_BIT] && blk_prog_en)) |=> !fill_busy);
  assert_bp_format_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bp_we |-> ((bp_wdata & ~(16'h0007 << BP_POS)) == '0));
  assert_lo_format_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lo_we |-> ((lo_wdata & ~(16'h000F << LO_POS)) == '0));
  assert_hi_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_we |-> (hi_wdata == '0));
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_we && $past(bp_we)) |-> (bp_addr == $past(bp_addr) + AW'(1)));
  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_busy && !blk_prog_en) |=> (!fill_busy && !bp_we && !cfg_rdata[START_BIT]));
endmodule

// File: tb/tb_cm_fill_ctrl.sv
module tb_cm_fill_ctrl;
  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);

  logic clk, rst_n, cfg_we, blk_prog_en, frame_pulse, fill_busy;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic bp_we, lo_we, hi_we;
  logic [AW-1:0] bp_addr, lo_addr, hi_addr;
  logic [15:0] bp_wdata, lo_wdata, hi_wdata;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  typedef struct { int addr; logic [15:0] data; } item_t;
  item_t q_bp[$], q_lo[$], q_hi[$];

  cm_fill_ctrl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .blk_prog_en(blk_prog_en), .frame_pulse(frame_pulse),
    .fill_busy(fill_busy), .bp_we(bp_we), .bp_addr(bp_addr), .bp_wdata(bp_wdata),
    .lo_we(lo_we), .lo_addr(lo_addr), .lo_wdata(lo_wdata),
    .hi_we(hi_we), .hi_addr(hi_addr), .hi_wdata(hi_wdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: expected writes for a fill of n addresses with the given values
  task automatic expect_fill(input int n, input logic [2:0] b, input logic [3:0] l);
    for (int a = 0; a < n; a++) begin
      q_bp.push_back('{a, {2'b00, b, 11'd0}});
      q_lo.push_back('{a, {l, 12'd0}});
      q_hi.push_back('{a, 16'h0000});
    end
  endtask

  task automatic wr(input logic [15:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic fp();
    frame_pulse = 1'b1;
    @(negedge clk);
    frame_pulse = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic queues_empty(input string req);
    check(q_bp.size() == 0 && q_lo.size() == 0 && q_hi.size() == 0, req,
          q_bp.size() + q_lo.size() + q_hi.size(), 0);
  endtask

  // monitor: pops and compares every memory write (R4 R5 R6)
  task automatic pop_cmp(ref item_t q[$], input string req, input int addr, input logic [15:0] data);
    item_t e;
    if (q.size() == 0) begin
      check(1'b0, {req, " unexpected write"}, addr, 32'hFFFF_FFFF);
    end else begin
      e = q.pop_front();
      check(addr == e.addr, {req, " addr"}, addr, e.addr);
      check(data == e.data, {req, " data"}, data, e.data);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (bp_we) pop_cmp(q_bp, "R4 R6 bp", int'(bp_addr), bp_wdata);
      if (lo_we) pop_cmp(q_lo, "R5 R6 lo", int'(lo_addr), lo_wdata);
      if (hi_we) pop_cmp(q_hi, "R5 R6 hi", int'(hi_addr), hi_wdata);
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; blk_prog_en = 1'b0; frame_pulse = 1'b0;
    idle(3);
    check(cfg_rdata == 16'h0000, "R1 rdata", cfg_rdata, 0);
    check(!fill_busy, "R1 busy", fill_busy, 0);
    check(!bp_we && !lo_we && !hi_we, "R1 we", {bp_we, lo_we, hi_we}, 0);
    rst_n = 1'b1;
    idle(2);

    // R2 R3: start written with enable low, reserved bits dropped
    wr(16'hFC07);
    check(cfg_rdata == 16'h0007, "R2 readback", cfg_rdata, 16'h0007);
    check(!fill_busy, "R3 enable low", fill_busy, 0);
    blk_prog_en = 1'b1;
    idle(3);
    check(!fill_busy, "R3 no edge", fill_busy, 0);
    wr(16'h0000);

    // R6 R7: full fill, b=5 l=A -> word 0x2D4
    expect_fill(DEPTH, 3'd5, 4'hA);
    wr(16'h02D4);
    check(fill_busy, "R3 launch", fill_busy, 1);
    idle(40); fp();
    check(fill_busy, "R7 one frame", fill_busy, 1);
    idle(40); fp();
    check(!fill_busy, "R7 done busy", fill_busy, 0);
    check(cfg_rdata == 16'h02D0, "R7 start cleared", cfg_rdata, 16'h02D0);
    queues_empty("R6 all written");

    // R9: rewrite fields while busy with start kept at 1
    expect_fill(DEPTH, 3'd7, 4'hF);
    wr(16'h03FC);
    idle(5);
    wr(16'h008C);
    check(cfg_rdata == 16'h008C, "R9 reg updated", cfg_rdata, 16'h008C);
    idle(30); fp(); idle(40); fp();
    check(!fill_busy, "R9 done", fill_busy, 0);
    check(cfg_rdata == 16'h0088, "R9 start cleared", cfg_rdata, 16'h0088);
    queues_empty("R9 captured data");

    // R8: abort by writing start 0 after 10 writes issued
    expect_fill(10, 3'd5, 4'hA);
    wr(16'h02D4);
    idle(10);
    wr(16'h02D0);
    check(!fill_busy, "R8 write abort busy", fill_busy, 0);
    idle(4);
    queues_empty("R8 write abort count");

    // R8: abort by dropping enable after 5 writes
    expect_fill(5, 3'd5, 4'hA);
    wr(16'h02D4);
    idle(5);
    blk_prog_en = 1'b0;
    @(negedge clk);
    check(!fill_busy, "R8 enable abort busy", fill_busy, 0);
    check(cfg_rdata == 16'h02D0, "R8 enable abort start", cfg_rdata, 16'h02D0);
    blk_prog_en = 1'b1;
    idle(4);
    check(!fill_busy, "R3 fresh edge needed", fill_busy, 0);
    queues_empty("R8 enable abort count");

    // R10: completion pulse and register write in the same cycle
    wr(16'h0000);
    expect_fill(DEPTH, 3'd2, 4'h3);
    wr(16'h011C);
    idle(40); fp(); idle(40);
    frame_pulse = 1'b1; cfg_we = 1'b1; cfg_wdata = 16'h011F;
    @(negedge clk);
    frame_pulse = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    check(!fill_busy, "R10 done", fill_busy, 0);
    check(cfg_rdata == 16'h011F, "R10 write wins", cfg_rdata, 16'h011F);
    idle(4);
    check(!fill_busy, "R10 no relaunch", fill_busy, 0);
    queues_empty("R10 no extra writes");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule